// File: doc/BRIEF.md
# SIMD Signed Rounding Average Unit

This unit is a 128-bit vector execution stage. It averages two signed vector operands lane by lane and rounds halves upward. The lane width is 8, 16 or 32 bits. The width is chosen on every accepted input in one of two ways. When `use_insn` is high, the unit decodes a 32-bit register-to-register vector instruction word. When `use_insn` is low, a two-bit direct select `lane_sel` gives the width. The destination register index always comes from the instruction word, in both modes.

Bits are numbered most-significant-first, for the vector and for the instruction word. In the Verilog LSB-first numbering, MSB-first bit k of a 32-bit word is `insn[31-k]`. Lane i of width w covers MSB-first bits i*w to i*w+w-1, which is `opnd[127-i*w -: w]`. Each lane sum is formed at w+1 bits, so it cannot overflow. The sum plus one is then shifted right arithmetically and truncated back to w bits.

The result and the destination index are registered and appear one clock after the input is accepted. An input that does not decode raises a one-cycle illegal flag instead of a result. The unit updates no status of any kind.

Top module: `simd_avg_unit`

## Requirements
- R1: Operands split into 16 byte lanes, 8 halfword lanes or 4 word lanes. Lane i of width w is `opnd[127-i*w -: w]` (MSB-first bits i*w to i*w+w-1). No carry crosses a lane boundary at any width.
- R2: Each lane result is bits [w:1] of the (w+1)-bit sum sext(a)+sext(b)+1. Two examples: 127 with 127 gives 127, and -128 with -128 gives -128 (byte lanes).
- R3: A half-way sum rounds toward positive infinity. Examples: -1 with 0 gives 0, and -3 with 0 gives -1.
- R4: With `use_insn`=1, the instruction is legal only in these cases:
  - `insn[31:26]` (MSB-first bits 0-5) is 4, and
  - `insn[10:0]` (MSB-first bits 21-31) is 1282 (byte lanes), 1346 (halfword lanes) or 1410 (word lanes).
- R5: With `use_insn`=0, `lane_sel` 0 selects byte lanes, 1 halfword lanes and 2 word lanes. The value 3 is illegal. The opcode fields of `insn` are ignored in this mode.
- R6: `res_dst` carries `insn[25:21]` (MSB-first bits 6-10) of the accepted input, in both modes.
- R7: `res_valid` is high in exactly the cycle after a legal input is accepted with `in_valid`, and low in every other cycle.
- R8: An input accepted with an illegal decode drives `illegal_op` high in the next cycle, and `res_valid` stays low then. The two flags are never high together.
- R9: `res_data` and `res_dst` hold their values across idle cycles and across illegal inputs.
- R10: A synchronous active-high reset clears `res_valid`, `illegal_op`, `res_data` and `res_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept an operation this cycle |
| use_insn | input | 1 | 1: width from the instruction word; 0: width from `lane_sel` |
| insn | input | 32 | Instruction word, bit 31 is MSB-first bit 0 |
| lane_sel | input | 2 | Direct width select: 0 byte, 1 halfword, 2 word |
| opnd_a | input | 128 | First operand vector |
| opnd_b | input | 128 | Second operand vector |
| res_data | output | 128 | Registered averaged vector |
| res_dst | output | 5 | Registered destination register index |
| res_valid | output | 1 | Result valid, one cycle after acceptance |
| illegal_op | output | 1 | Accepted operation did not decode |

## Verification
Several properties are checked on every cycle:
- the flag protocol: no result without an accepted input, an answer after every accepted input, and the two flags mutually exclusive;
- rejection of a bad primary opcode and of the reserved direct select;
- the destination index following the instruction;
- data holding still when nothing is accepted.

The arithmetic itself can only be shown by the bench's reference scenarios. This covers lane placement, the absence of carries between lanes, saturating-free extremes and half-way rounding. The bench also shows which extended opcode maps to which width.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

    localparam int INSN_W   = 32;
    localparam int IDX_W    = 5;
    localparam int PRIM_W   = 6;
    localparam int XO_W     = 11;
    localparam int N_SIZES  = 3;

    localparam logic [PRIM_W-1:0] PRIM_VECTOR = 6'd4;
    localparam logic [XO_W-1:0]   XO_AVG_B    = 11'd1282;
    localparam logic [XO_W-1:0]   XO_AVG_H    = 11'd1346;
    localparam logic [XO_W-1:0]   XO_AVG_W    = 11'd1410;

    typedef enum logic [1:0] {
        LANE_B    = 2'd0,
        LANE_H    = 2'd1,
        LANE_W    = 2'd2,
        LANE_NONE = 2'd3
    } lane_e;

    typedef struct packed {
        lane_e            lane;
        logic [IDX_W-1:0] dst;
        logic             legal;
    } dec_t;

    // MSB-first field positions: bit k of the word is insn[INSN_W-1-k]
    function automatic logic [PRIM_W-1:0] fld_prim(input logic [INSN_W-1:0] w);
        return w[INSN_W-1 -: PRIM_W];
    endfunction

    function automatic logic [IDX_W-1:0] fld_dst(input logic [INSN_W-1:0] w);
        return w[INSN_W-1-PRIM_W -: IDX_W];
    endfunction

    function automatic logic [XO_W-1:0] fld_xo(input logic [INSN_W-1:0] w);
        return w[XO_W-1:0];
    endfunction

    function automatic lane_e xo_lane(input logic [XO_W-1:0] xo);
        case (xo)
            XO_AVG_B: return LANE_B;
            XO_AVG_H: return LANE_H;
            XO_AVG_W: return LANE_W;
            default:  return LANE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/simd_avg_decode.sv
module simd_avg_decode
    import simd_avg_pkg::*;
(
    input  logic              use_insn,
    input  logic [INSN_W-1:0] insn,
    input  logic [1:0]        lane_sel,
    output dec_t              dec
);
    lane_e lane_d;

    always_comb begin
        if (use_insn) begin
            lane_d = (fld_prim(insn) == PRIM_VECTOR) ? xo_lane(fld_xo(insn)) : LANE_NONE;
        end else begin
            lane_d = lane_e'(lane_sel);
        end
        dec.lane  = lane_d;
        dec.dst   = fld_dst(insn);
        dec.legal = (lane_d != LANE_NONE);
    end
endmodule

// File: rtl/simd_avg_lanes.sv
module simd_avg_lanes #(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] y
);
    localparam int N_LANES = VEC_W / LANE_W;
    localparam logic [LANE_W:0] ONE = {{LANE_W{1'b0}}, 1'b1};

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int HI = VEC_W - 1 - g * LANE_W;
        logic [LANE_W:0] sum;
        // one guard bit per lane: the sum never wraps, no carry leaves the lane
        assign sum = {a[HI], a[HI -: LANE_W]} + {b[HI], b[HI -: LANE_W]} + ONE;
        assign y[HI -: LANE_W] = sum[LANE_W:1];
    end
endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
    import simd_avg_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              use_insn,
    input  logic [31:0]       insn,
    input  logic [1:0]        lane_sel,
    input  logic [VEC_W-1:0]  opnd_a,
    input  logic [VEC_W-1:0]  opnd_b,
    output logic [VEC_W-1:0]  res_data,
    output logic [4:0]        res_dst,
    output logic              res_valid,
    output logic              illegal_op
);
    dec_t             dec;
    logic [VEC_W-1:0] size_res [N_SIZES];
    logic [VEC_W-1:0] pick;
    logic             take;

    simd_avg_decode u_dec (
        .use_insn (use_insn),
        .insn     (insn),
        .lane_sel (lane_sel),
        .dec      (dec)
    );

    for (genvar k = 0; k < N_SIZES; k++) begin : g_size
        simd_avg_lanes #(.VEC_W(VEC_W), .LANE_W(8 << k)) u_lanes (
            .a (opnd_a),
            .b (opnd_b),
            .y (size_res[k])
        );
    end

    always_comb begin
        case (dec.lane)
            LANE_H:  pick = size_res[1];
            LANE_W:  pick = size_res[2];
            default: pick = size_res[0];
        endcase
    end

    assign take = in_valid && dec.legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            illegal_op <= 1'b0;
            res_data   <= '0;
            res_dst    <= '0;
        end else begin
            res_valid  <= take;
            illegal_op <= in_valid && !dec.legal;
            if (take) begin
                res_data <= pick;
                res_dst  <= dec.dst;
            end
        end
    end
endmodule

// File: rtl/simd_avg_check.sv
module simd_avg_check #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             use_insn,
    input logic [31:0]      insn,
    input logic [1:0]       lane_sel,
    input logic [VEC_W-1:0] opnd_a,
    input logic [VEC_W-1:0] opnd_b,
    input logic [VEC_W-1:0] res_data,
    input logic [4:0]       res_dst,
    input logic             res_valid,
    input logic             illegal_op
);
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (!res_valid && !illegal_op));

    a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!res_valid && !illegal_op));

    a_r8_accept_answers: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (res_valid || illegal_op));

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && illegal_op));

    a_r4_bad_primary: assert property (@(posedge clk) disable iff (rst)
        (in_valid && use_insn && insn[31:26] != 6'd4) |=> illegal_op);

    a_r5_direct_reserved: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !use_insn && lane_sel == 2'd3) |=> illegal_op);

    a_r6_dst_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (!res_valid || res_dst == $past(insn[25:21])));

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_data) && $stable(res_dst)));
endmodule

bind simd_avg_unit simd_avg_check #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/tb_simd_avg_unit.sv
`timescale 1ns/1ps
module tb_simd_avg_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         use_insn;
    logic [31:0]  insn;
    logic [1:0]   lane_sel;
    logic [127:0] opnd_a, opnd_b;
    logic [127:0] res_data;
    logic [4:0]   res_dst;
    logic         res_valid, illegal_op;

    always #2.5 clk = ~clk;

    simd_avg_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .use_insn(use_insn),
        .insn(insn), .lane_sel(lane_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_data(res_data), .res_dst(res_dst), .res_valid(res_valid),
        .illegal_op(illegal_op)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;
    int  cur_w;

    logic [127:0] exp_data;
    logic [4:0]   exp_dst;
    logic         exp_valid, exp_ill;

    // R4 / R5: lane width in bits, 0 when illegal
    function automatic int ref_width(input logic ui, input logic [31:0] ins, input logic [1:0] ls);
        if (ui) begin
            if (ins[31:26] != 6'd4) return 0;
            case (int'(ins[10:0]))
                1282: return 8;
                1346: return 16;
                1410: return 32;
                default: return 0;
            endcase
        end
        case (ls)
            2'd0: return 8;
            2'd1: return 16;
            2'd2: return 32;
            default: return 0;
        endcase
    endfunction

    // R1 / R2 / R3: integer reference of the rounded signed average
    function automatic logic [127:0] ref_avg(input logic [127:0] a, input logic [127:0] b, input int w);
        logic [127:0] r, ta, tb;
        longint x, y, s, m;
        r = '0;
        m = (longint'(1) << w) - 1;
        for (int i = 0; i < 128 / w; i++) begin
            ta = a >> (128 - (i + 1) * w);
            tb = b >> (128 - (i + 1) * w);
            x = longint'(ta[31:0]) & m;
            y = longint'(tb[31:0]) & m;
            if (x[w-1]) x = x - (longint'(1) << w);
            if (y[w-1]) y = y - (longint'(1) << w);
            s = (x + y + 1) >>> 1;
            r = r | ((128'(s & m)) << (128 - (i + 1) * w));
        end
        return r;
    endfunction

    function automatic logic [31:0] mk_insn(input logic [5:0] p, input logic [4:0] d, input logic [10:0] xo);
        return {p, d, 5'd3, 5'd7, xo};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_ill   <= 1'b0;
            exp_data  <= '0;
            exp_dst   <= '0;
        end else begin
            cur_w = ref_width(use_insn, insn, lane_sel);
            exp_valid <= in_valid && (cur_w != 0);
            exp_ill   <= in_valid && (cur_w == 0);
            if (in_valid && cur_w != 0) begin
                exp_data <= ref_avg(opnd_a, opnd_b, cur_w);
                exp_dst  <= insn[25:21];
            end
        end
    end

    task automatic fail(input string tag, input logic [127:0] act, input logic [127:0] expv);
        n_bad++;
        $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
    endtask

    // compared every cycle; covers R10 during reset, R9 while holding
    task automatic step();
        @(negedge clk);
        n_vec++;
        if (res_valid !== exp_valid)  fail("R7 res_valid", 128'(res_valid), 128'(exp_valid));
        if (illegal_op !== exp_ill)   fail("R8 illegal_op", 128'(illegal_op), 128'(exp_ill));
        if (res_data !== exp_data)    fail("R2 res_data", res_data, exp_data);
        if (res_dst !== exp_dst)      fail("R6 res_dst", 128'(res_dst), 128'(exp_dst));
    endtask

    task automatic apply(input logic v, input logic ui, input logic [31:0] ins,
                         input logic [1:0] ls, input logic [127:0] a, input logic [127:0] b);
        step();
        in_valid = v; use_insn = ui; insn = ins; lane_sel = ls; opnd_a = a; opnd_b = b;
    endtask

    initial begin
        rst = 1'b1; in_valid = 0; use_insn = 0; insn = '0; lane_sel = '0;
        opnd_a = '0; opnd_b = '0;
        repeat (3) step();                 // R10 reset state
        rst = 1'b0;
        // R2 extremes, byte lanes
        apply(1, 1, mk_insn(6'd4, 5'd9, 11'd1282), 0, {16{8'h7f}}, {16{8'h7f}});
        apply(1, 1, mk_insn(6'd4, 5'd10, 11'd1282), 0, {16{8'h80}}, {16{8'h80}});
        // R3 half-way rounding
        apply(1, 1, mk_insn(6'd4, 5'd11, 11'd1346), 0, {8{16'hffff}}, '0);
        apply(1, 1, mk_insn(6'd4, 5'd12, 11'd1410), 0, {4{32'hfffffffd}}, '0);
        // R1 no carry between lanes, distinct lane contents
        apply(1, 1, mk_insn(6'd4, 5'd13, 11'd1346), 0, {8{16'h00ff}}, {8{16'h0001}});
        apply(1, 0, '0, 2'd0, 128'h00010203_04050607_08090a0b_0c0d0e0f, {16{8'h7f}});
        apply(1, 0, '0, 2'd2, {4{32'h7fffffff}}, {4{32'h00000001}});
        // R4 bad primary and bad extended opcode; R9 hold
        apply(1, 1, mk_insn(6'd5, 5'd1, 11'd1282), 0, '1, '1);
        apply(1, 1, mk_insn(6'd4, 5'd2, 11'd1283), 0, '1, '1);
        // R5 reserved direct select, then opcode ignored in direct mode
        apply(1, 0, mk_insn(6'd4, 5'd3, 11'd1282), 2'd3, '1, '1);
        apply(1, 0, mk_insn(6'd63, 5'd4, 11'd0), 2'd1, {8{16'h8000}}, {8{16'h7fff}});
        apply(0, 1, mk_insn(6'd4, 5'd5, 11'd1282), 0, '1, '1);   // R9 idle
        for (int n = 0; n < 4000; n++) begin
            logic [10:0] xo;
            logic [5:0]  p;
            logic [127:0] ra, rb;
            case ($urandom_range(0, 4))
                0: xo = 11'd1282;
                1: xo = 11'd1346;
                2: xo = 11'd1410;
                3: xo = 11'($urandom);
                default: xo = 11'd1282 + 11'($urandom_range(0, 3) * 64);
            endcase
            p  = ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'd4;
            ra = {$urandom, $urandom, $urandom, $urandom};
            rb = ($urandom_range(0, 3) == 0) ? ra : {$urandom, $urandom, $urandom, $urandom};
            apply($urandom_range(0, 3) != 0, 1'($urandom), mk_insn(p, 5'($urandom), xo),
                  2'($urandom), ra, rb);
        end
        apply(0, 0, '0, 0, '0, '0);
        step();
        step();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule